// File: doc/BRIEF.md
# Auto-Reload Programmable Interval Timer

This block is a down-counting interval timer that advances once for every pulse of a time-base tick enable. Software writes a reload value and a two-bit control word (a combined run/interrupt enable and an auto-reload select). It reads back the live remaining count, a sticky expiry flag and an interrupt request. When the count steps from 1 to 0, the block sets its expiry flag. It then either reloads the count from the reload register and keeps running, or stops at zero.

The timer never runs while the reload value is 0 or 1. One enable bit gates both the counting and the interrupt. In periodic mode the next deadline follows directly from the previous one: the count is reloaded on the same tick that expires, so every period is exactly the reload value in ticks and no drift builds up. Writing a new reload value while the run conditions hold restarts the count from that value.

The controller has two states. ST_IDLE holds the count. ST_RUN decrements the count on each tick. The transitions are named as follows. Start: ST_IDLE to ST_RUN, on a reload write or a control write that leaves the run conditions true. Restart: ST_RUN to ST_RUN with the count loaded, on a reload write. Reload: ST_RUN to ST_RUN at expiry with auto-reload set. One-shot stop: ST_RUN to ST_IDLE at expiry without auto-reload. Halt: any state to ST_IDLE when the enable is clear or the reload value is at most 1.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is 0, the expiry flag is 0, the interrupt is 0, and the timer is stopped with enable, auto-reload and reload value all 0.
- R2: While running, the count falls by exactly one on each cycle where `tick` is 1. It holds on cycles where `tick` is 0.
- R3: With a reload value of 0 or 1, the timer does not start and does not expire, and the count holds.
- R4: When the enable bit is clear, the count holds and the interrupt output is 0, even if the expiry flag is set.
- R5: A tick that takes the count from 1 to 0 sets the expiry flag on the next cycle. The interrupt output equals the expiry flag ANDed with the enable bit.
- R6: With auto-reload set, the expiring tick loads the count with the reload value and the timer keeps running. Expiries therefore repeat exactly every reload-value ticks.
- R7: With auto-reload clear, the expiring tick leaves the count at 0 and stops the timer. It stays stopped until a reload write or a control write.
- R8: A pulse on `stat_clr` clears the expiry flag. If an expiry and a clear arrive in the same cycle, the flag ends up set.
- R9: A control write that sets enable while the timer is stopped and the reload value is above 1 starts the count from the reload value.
- R10: A reload write of a value above 1 with enable set loads the count with that value on the next cycle, whether the timer was running or stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable, one count per pulse |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_wdata | input | W | New reload value |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_en | input | 1 | Run and interrupt enable |
| ctrl_auto | input | 1 | Auto-reload select |
| stat_clr | input | 1 | Write-one-to-clear pulse for the expiry flag |
| count | output | W | Live remaining count |
| expired | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
Every result is registered, so the count, the expiry flag and the interrupt all show the effect of a stimulus one clock after the edge that samples it. The interrupt follows the flag and enable registers in the same cycle, with no extra delay. The bench drives its inputs on the falling edge. It advances a behavioural reference model by one step for those inputs, waits for the next rising edge, and compares all three outputs with the model on the following falling edge. Each comparison therefore lands exactly one cycle after its stimulus. Multi-tick results, such as an expiry N ticks after a load or a reload period, come out of the accumulated per-cycle comparisons, with no separate delay bookkeeping.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload_we,
    input  logic [W-1:0] reload_wdata,
    input  logic         ctrl_we,
    input  logic         ctrl_en,
    input  logic         ctrl_auto,
    output logic [W-1:0] reload_q,
    output logic         en_q,
    output logic         auto_q,
    output logic [W-1:0] reload_nx,
    output logic         en_nx,
    output logic         auto_nx
);
    // Values that will be visible after this edge; the FSM decides on them.
    always_comb begin
        reload_nx = reload_we ? reload_wdata : reload_q;
        en_nx     = ctrl_we ? ctrl_en : en_q;
        auto_nx   = ctrl_we ? ctrl_auto : auto_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            en_q     <= 1'b0;
            auto_q   <= 1'b0;
        end else begin
            reload_q <= reload_nx;
            en_q     <= en_nx;
            auto_q   <= auto_nx;
        end
    end
endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reload_we,
    input  logic         ctrl_we,
    input  logic [W-1:0] reload_nx,
    input  logic         en_nx,
    input  logic         auto_nx,
    output tmr_state_e   state_q,
    output logic [W-1:0] count_q,
    output logic         expire
);
    localparam logic [W-1:0] CNT_ONE = W'(1);

    tmr_state_e   state_d;
    logic [W-1:0] count_d;
    logic         can_run;

    // Running needs the enable bit and a reload value above one.
    assign can_run = en_nx && (reload_nx > CNT_ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (can_run && (reload_we || ctrl_we)) begin
                    state_d = ST_RUN;
                    count_d = reload_nx;
                end
            end
            ST_RUN: begin
                expire = tick && (count_q == CNT_ONE);
                if (!can_run) begin
                    state_d = ST_IDLE;
                end else if (reload_we) begin
                    count_d = reload_nx;
                end else if (tick) begin
                    if (count_q == CNT_ONE) begin
                        if (auto_nx) begin
                            count_d = reload_nx;
                        end else begin
                            count_d = '0;
                            state_d = ST_IDLE;
                        end
                    end else begin
                        count_d = count_q - CNT_ONE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/tmr_status.sv
module tmr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic stat_clr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (stat_clr) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reload_we,
    input  logic [W-1:0] reload_wdata,
    input  logic         ctrl_we,
    input  logic         ctrl_en,
    input  logic         ctrl_auto,
    input  logic         stat_clr,
    output logic [W-1:0] count,
    output logic         expired,
    output logic         irq
);
    logic [W-1:0] reload_q;
    logic [W-1:0] reload_nx;
    logic         en_q;
    logic         en_nx;
    logic         auto_q;
    logic         auto_nx;
    logic         expire;
    tmr_state_e   state_q;

    tmr_cfg_regs #(.W(W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .ctrl_we      (ctrl_we),
        .ctrl_en      (ctrl_en),
        .ctrl_auto    (ctrl_auto),
        .reload_q     (reload_q),
        .en_q         (en_q),
        .auto_q       (auto_q),
        .reload_nx    (reload_nx),
        .en_nx        (en_nx),
        .auto_nx      (auto_nx)
    );

    tmr_count_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reload_we (reload_we),
        .ctrl_we   (ctrl_we),
        .reload_nx (reload_nx),
        .en_nx     (en_nx),
        .auto_nx   (auto_nx),
        .state_q   (state_q),
        .count_q   (count),
        .expire    (expire)
    );

    tmr_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .stat_clr (stat_clr),
        .flag_q   (expired)
    );

    // One bit gates the interrupt as well as the counting.
    assign irq = expired && en_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         reload_we,
    input logic         ctrl_we,
    input logic         stat_clr,
    input logic [W-1:0] count,
    input logic         expired,
    input logic         irq,
    input tmr_state_e   state_q,
    input logic [W-1:0] reload_q,
    input logic         en_q,
    input logic         auto_q
);
    logic quiet;
    logic at_end;
    assign quiet  = !reload_we && !ctrl_we;
    assign at_end = (state_q == ST_RUN) && tick && (count == W'(1)) && quiet;

    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && !tick && quiet) |=> $stable(count));

    // R3
    run_needs_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (reload_q > W'(1)));

    // R4
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q && expired));

    // R5
    expiry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> expired);

    // R6
    auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && auto_q) |=> ((count == $past(reload_q)) && (state_q == ST_RUN)));

    // R7
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !auto_q) |=> ((count == '0) && (state_q == ST_IDLE)));

    // R8
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !((state_q == ST_RUN) && tick && (count == W'(1)))) |=> !expired);
endmodule

bind interval_timer tmr_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reload_we (reload_we),
    .ctrl_we   (ctrl_we),
    .stat_clr  (stat_clr),
    .count     (count),
    .expired   (expired),
    .irq       (irq),
    .state_q   (state_q),
    .reload_q  (reload_q),
    .en_q      (en_q),
    .auto_q    (auto_q)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         reload_we = 1'b0;
    logic [W-1:0] reload_wdata = '0;
    logic         ctrl_we = 1'b0;
    logic         ctrl_en = 1'b0;
    logic         ctrl_auto = 1'b0;
    logic         stat_clr = 1'b0;
    logic [W-1:0] count;
    logic         expired;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    int m_cnt = 0;
    int m_rel = 0;
    bit m_en = 0;
    bit m_auto = 0;
    bit m_run = 0;
    bit m_flag = 0;
    int exp_seen = 0;

    always #10 clk = ~clk;

    interval_timer #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .reload_we(reload_we), .reload_wdata(reload_wdata),
        .ctrl_we(ctrl_we), .ctrl_en(ctrl_en), .ctrl_auto(ctrl_auto),
        .stat_clr(stat_clr), .count(count), .expired(expired), .irq(irq)
    );

    task automatic compare();
        checks++;
        if (int'(count) != m_cnt || expired != m_flag || irq != (m_flag && m_en)) begin
            errors++;
            $display("FAIL %s: count=%0d flag=%0b irq=%0b expected count=%0d flag=%0b irq=%0b",
                     tag, count, expired, irq, m_cnt, m_flag, m_flag && m_en);
        end
    endtask

    task automatic model_step();
        int  rel_n;
        bit  en_n, au_n, hit;
        rel_n = reload_we ? int'(reload_wdata) : m_rel;
        en_n  = ctrl_we ? ctrl_en : m_en;
        au_n  = ctrl_we ? ctrl_auto : m_auto;
        hit   = m_run && tick && (m_cnt == 1);
        if (hit) exp_seen++;
        if (hit) m_flag = 1;
        else if (stat_clr) m_flag = 0;
        if (!(en_n && rel_n > 1)) begin
            m_run = 0;
        end else if (reload_we || (!m_run && ctrl_we)) begin
            m_run = 1;
            m_cnt = rel_n;
        end else if (m_run && tick) begin
            if (m_cnt == 1) begin
                m_cnt = au_n ? rel_n : 0;
                m_run = au_n;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        m_rel = rel_n; m_en = en_n; m_auto = au_n;
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        cycles++;
        @(negedge clk);
        compare();
        tick = 1'b0; reload_we = 1'b0; ctrl_we = 1'b0; stat_clr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
        end
    endtask

    task automatic wr_reload(int v);
        reload_we = 1'b1; reload_wdata = W'(v);
        step();
    endtask

    task automatic wr_ctrl(bit en, bit au);
        ctrl_we = 1'b1; ctrl_en = en; ctrl_auto = au;
        step();
    endtask

    task automatic expect_val(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        step(); step();
        expect_val("R1", int'(count), 0);

        tag = "R3";
        wr_ctrl(1, 0);
        ticks(3);
        wr_reload(1);
        ticks(4);
        wr_reload(0);
        ticks(2);
        expect_val("R3", int'(count), 0);

        tag = "R2";
        wr_reload(5);
        expect_val("R10", int'(count), 5);
        ticks(1); step(); step(); ticks(2); step();
        expect_val("R2", int'(count), 2);

        tag = "R5";
        base = exp_seen;
        ticks(2);
        expect_val("R5", int'(irq), 1);
        tag = "R7";
        ticks(4);
        expect_val("R7", int'(count), 0);
        expect_val("R7", exp_seen - base, 1);

        tag = "R8";
        stat_clr = 1'b1; step();
        expect_val("R8", int'(expired), 0);
        wr_reload(3);
        tick = 1'b1; stat_clr = 1'b1; step();
        tick = 1'b1; stat_clr = 1'b1; step();
        tick = 1'b1; stat_clr = 1'b1; step();
        expect_val("R8", int'(expired), 1);
        stat_clr = 1'b1; step();

        tag = "R9";
        wr_ctrl(0, 0);
        wr_reload(4);
        wr_ctrl(1, 1);
        expect_val("R9", int'(count), 4);

        tag = "R6";
        base = exp_seen;
        ticks(20);
        expect_val("R6", exp_seen - base, 5);
        expect_val("R6", int'(count), 4);

        tag = "R10";
        ticks(2);
        wr_reload(7);
        expect_val("R10", int'(count), 7);
        ticks(3);

        tag = "R4";
        wr_ctrl(0, 1);
        ticks(5);
        expect_val("R4", int'(count), 4);
        expect_val("R4", int'(irq), 0);
        wr_ctrl(1, 1);
        ticks(9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule